// File: doc/BRIEF.md
# Register-Machine Integer ALU with Byte-Order Conversion

This block is the combinational execute stage for the integer arithmetic class of a 64-bit register-based virtual machine. It receives the decoded fields of one arithmetic instruction and the two register values read for it. These fields are a 4-bit operation code, a source-select bit, a width-mode bit, the 16-bit offset field and the 32-bit immediate. The block returns the value to write back to the destination register, together with a flag that marks an encoding it does not accept.

It supports add, subtract, bitwise logic, the three shifts, negate, plain and sign-extending moves, and the endian-conversion operation. The endian conversion depends on a host byte-order parameter. Multiply, divide and modulo are not implemented here and are reported as illegal. Register-file access and write-back gating are left to the surrounding pipeline. When the flag is raised, the destination value passes through unchanged.

Top module: `vm_int_alu`

## Requirements
- R1: Operation codes are ADD 0x0, SUB 0x1, OR 0x4, AND 0x5 and XOR 0xa. In 64-bit mode (`wide_mode`=1) these act on full 64-bit values and wrap on overflow.
- R2: In 32-bit mode (`wide_mode`=0), operands are truncated to 32 bits and `result[63:32]` is zero for every legal operation except the endian conversion with width 64.
- R3: With `use_reg`=0, the source operand is the immediate sign-extended to 64 bits. MOV (0xb) with offset 0 copies the source, so a MOV of an immediate in 64-bit mode gives the sign-extended immediate. With `use_reg`=1, the source operand is `src_val`.
- R4: LSH 0x6, RSH 0x7 and ARSH 0xc take the shift amount as the source operand masked with 0x3F in 64-bit mode and with 0x1F in 32-bit mode. ARSH fills vacated bits with bit 63 in 64-bit mode and with bit 31 in 32-bit mode.
- R5: MOV with offset 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of `src_val`. In 32-bit mode only offsets 8 and 16 are accepted, and the value is sign-extended to 32 bits. These forms require `use_reg`=1.
- R6: NEG 0x8 returns the two's complement of `dst_val` and is legal only with `use_reg`=0.
- R7: The endian conversion 0xd uses only `dst_val`. Its width comes from the immediate, which must be 16, 32 or 64. A 16- or 32-bit result is zero-extended to 64 bits.
- R8: For the endian conversion in 32-bit mode, `use_reg`=0 requests little-endian and `use_reg`=1 requests big-endian. When the request matches `HOST_BIG_ENDIAN`, the value is only truncated to the width; otherwise its bytes are reversed. In 64-bit mode the bytes are always reversed, and `use_reg` must be 0.
- R9: `illegal` is raised in these cases: codes 0x2, 0x3, 0x9, 0xe and 0xf; a nonzero offset on any operation other than MOV; a MOV offset other than those in R5; and the forms ruled out in R5 to R8. Whenever `illegal` is raised, `result` equals `dst_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation code |
| use_reg | input | 1 | 1: source is `src_val`; 0: source is the immediate (byte-order request for 0xd) |
| wide_mode | input | 1 | 1: 64-bit mode; 0: 32-bit mode |
| offset_in | input | 16 | Instruction offset field |
| imm_in | input | 32 | Instruction immediate field |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| result | output | 64 | New destination value |
| illegal | output | 1 | Encoding not accepted |

## Verification
The hardest cases to reach are the combinations in which two fields interact. Examples are a sign-extending move whose offset is legal in one mode only, and an endian conversion whose outcome depends on mode, request bit, width and host order together. The stimulus therefore sweeps every operation code against both modes, both source-select values, a spread of offsets and immediates, and operands chosen with the top bit of each width set. The same stimulus drives a little-endian instance and a big-endian instance, so that both truncation and byte-reversal paths of the conversion are covered.

// File: rtl/vm_alu_pkg.sv
// Package: shared operation codes and helpers for the integer ALU.
// Assumes a 4-bit operation field as delivered by the instruction decoder.
package vm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc,
        OP_BSW  = 4'hd,
        OP_RSVE = 4'he,
        OP_RSVF = 4'hf
    } alu_op_e;

    // Widths accepted by the endian conversion, given in bits.
    localparam int BSW_W16 = 16;
    localparam int BSW_W32 = 32;
    localparam int BSW_W64 = 64;

endpackage

// File: rtl/vm_alu_operand.sv
// Operand selector: picks the register value or the sign-extended immediate.
// Assumes IMM_W <= DATA_W.
module vm_alu_operand #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm_in,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] src_op
);
    localparam int EXT_W = DATA_W - IMM_W;

    // Select the source operand; the immediate is always widened by its sign.
    always_comb begin
        if (use_reg) src_op = src_val;
        else         src_op = {{EXT_W{imm_in[IMM_W-1]}}, imm_in};
    end
endmodule

// File: rtl/vm_alu_shifter.sv
// Shift unit: left, logical right and arithmetic right shifts.
// Width-mode dependent amount masking and sign fill.
// Assumes DATA_W is a power of two; the caller truncates the 32-bit mode result.
module vm_alu_shifter #(
    parameter int DATA_W = 64
) (
    input  logic              wide_mode,
    input  logic [1:0]        kind,       // 0 left, 1 logical right, 2 arithmetic right
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] amount,
    output logic [DATA_W-1:0] shifted
);
    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);

    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] val_n;
    logic [DATA_W-1:0] val_s;

    // Mask the shift amount to the active operand width.
    always_comb begin
        amt = amount[AMT_W-1:0];
        if (!wide_mode) amt[AMT_W-1] = 1'b0;
    end

    // Prepare zero- and sign-extended views of the operand for right shifts.
    always_comb begin
        if (wide_mode) begin
            val_n = value;
            val_s = value;
        end else begin
            val_n = {{HALF_W{1'b0}}, value[HALF_W-1:0]};
            val_s = {{HALF_W{value[HALF_W-1]}}, value[HALF_W-1:0]};
        end
    end

    // Perform the requested shift.
    always_comb begin
        case (kind)
            2'd0:    shifted = value << amt;
            2'd1:    shifted = val_n >> amt;
            default: shifted = DATA_W'($signed(val_s) >>> amt);
        endcase
    end
endmodule

// File: rtl/vm_alu_byteorder.sv
// Endian conversion unit. The request is either truncated to the selected
// width or byte-reversed within it, and the result is zero-extended.
// Assumes a legal width code (16/32/64); the legality unit flags the rest.
module vm_alu_byteorder #(
    parameter bit HOST_BIG_ENDIAN = 1'b0,
    parameter int DATA_W = 64
) (
    input  logic              wide_mode,
    input  logic              want_big,
    input  logic [7:0]        width_bits,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] converted
);
    localparam int NBYTES = DATA_W / 8;

    logic native_req;
    logic do_swap;
    int   nb;

    // The request is native when it names the host's own byte order.
    generate
        if (HOST_BIG_ENDIAN) begin : g_host_be
            assign native_req = want_big;
        end else begin : g_host_le
            assign native_req = !want_big;
        end
    endgenerate

    // 64-bit mode always reverses; 32-bit mode reverses on a foreign request.
    always_comb begin
        do_swap = wide_mode || !native_req;
        nb      = int'(width_bits) / 8;
    end

    // Build the truncated or reversed value, byte by byte.
    always_comb begin
        converted = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) begin
                if (do_swap) converted[8*i +: 8] = value[8*(nb-1-i) +: 8];
                else         converted[8*i +: 8] = value[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/vm_alu_legal.sv
// Legality decoder: flags encodings the execute unit does not accept.
// Assumes fields come straight from the instruction word, unmodified.
module vm_alu_legal #(
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [3:0]       op_code,
    input  logic             use_reg,
    input  logic             wide_mode,
    input  logic [OFF_W-1:0] offset_in,
    input  logic [IMM_W-1:0] imm_in,
    output logic             illegal
);
    import vm_alu_pkg::*;

    logic off_zero;
    logic movsx_ok;
    logic width_ok;

    // Pre-decode the field conditions shared by several operations.
    always_comb begin
        off_zero = (offset_in == '0);
        movsx_ok = use_reg && ((offset_in == OFF_W'(8)) || (offset_in == OFF_W'(16)) ||
                               (wide_mode && offset_in == OFF_W'(32)));
        width_ok = (imm_in == IMM_W'(BSW_W16)) || (imm_in == IMM_W'(BSW_W32)) ||
                   (imm_in == IMM_W'(BSW_W64));
    end

    // Combine per-operation rules into one flag.
    always_comb begin
        case (alu_op_e'(op_code))
            OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR,
            OP_LSH, OP_RSH, OP_ARSH: illegal = !off_zero;
            OP_NEG:  illegal = !off_zero || use_reg;
            OP_MOV:  illegal = !off_zero && !movsx_ok;
            OP_BSW:  illegal = !off_zero || !width_ok || (wide_mode && use_reg);
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/vm_int_alu.sv
// Integer execute unit for the arithmetic class of a 64-bit register machine.
// Purely combinational; the caller registers the result and gates write-back.
// Assumes DATA_W = 2*IMM_W.
module vm_int_alu #(
    parameter bit HOST_BIG_ENDIAN = 1'b0,
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16
) (
    input  logic [3:0]        op_code,
    input  logic              use_reg,
    input  logic              wide_mode,
    input  logic [OFF_W-1:0]  offset_in,
    input  logic [IMM_W-1:0]  imm_in,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    import vm_alu_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] src_op;
    logic [DATA_W-1:0] shift_out;
    logic [DATA_W-1:0] bsw_out;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] movsx;
    logic [1:0]        shift_kind;
    logic              bad;

    vm_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .use_reg (use_reg),
        .imm_in  (imm_in),
        .src_val (src_val),
        .src_op  (src_op)
    );

    // Map the operation code onto the shifter's kind selector.
    always_comb begin
        case (alu_op_e'(op_code))
            OP_LSH:  shift_kind = 2'd0;
            OP_RSH:  shift_kind = 2'd1;
            default: shift_kind = 2'd2;
        endcase
    end

    vm_alu_shifter #(.DATA_W(DATA_W)) u_shifter (
        .wide_mode (wide_mode),
        .kind      (shift_kind),
        .value     (dst_val),
        .amount    (src_op),
        .shifted   (shift_out)
    );

    vm_alu_byteorder #(.HOST_BIG_ENDIAN(HOST_BIG_ENDIAN), .DATA_W(DATA_W)) u_byteorder (
        .wide_mode  (wide_mode),
        .want_big   (use_reg),
        .width_bits (imm_in[7:0]),
        .value      (dst_val),
        .converted  (bsw_out)
    );

    vm_alu_legal #(.OFF_W(OFF_W), .IMM_W(IMM_W)) u_legal (
        .op_code   (op_code),
        .use_reg   (use_reg),
        .wide_mode (wide_mode),
        .offset_in (offset_in),
        .imm_in    (imm_in),
        .illegal   (bad)
    );

    // Sign-extending move: widen the low part of the source register.
    always_comb begin
        case (offset_in)
            OFF_W'(8):  movsx = {{(DATA_W-8){src_val[7]}}, src_val[7:0]};
            OFF_W'(16): movsx = {{(DATA_W-16){src_val[15]}}, src_val[15:0]};
            default:    movsx = {{HALF_W{src_val[HALF_W-1]}}, src_val[HALF_W-1:0]};
        endcase
    end

    // Compute the full-width result of the selected operation.
    always_comb begin
        case (alu_op_e'(op_code))
            OP_ADD:  raw = dst_val + src_op;
            OP_SUB:  raw = dst_val - src_op;
            OP_OR:   raw = dst_val | src_op;
            OP_AND:  raw = dst_val & src_op;
            OP_XOR:  raw = dst_val ^ src_op;
            OP_LSH, OP_RSH, OP_ARSH: raw = shift_out;
            OP_NEG:  raw = '0 - dst_val;
            OP_MOV:  raw = (offset_in == '0) ? src_op : movsx;
            OP_BSW:  raw = bsw_out;
            default: raw = dst_val;
        endcase
    end

    // Apply 32-bit truncation (not to byte conversion) and illegal pass-through.
    always_comb begin
        illegal = bad;
        if (bad)
            result = dst_val;
        else if (!wide_mode && alu_op_e'(op_code) != OP_BSW)
            result = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        else
            result = raw;
    end
endmodule

// File: rtl/vm_int_alu_chk.sv
// Checker for vm_int_alu: port-level properties, evaluated on every input change.
// Assumes the default 64/32/16 field widths.
module vm_int_alu_chk (
    input logic [3:0]  op_code,
    input logic        use_reg,
    input logic        wide_mode,
    input logic [15:0] offset_in,
    input logic [31:0] imm_in,
    input logic [63:0] dst_val,
    input logic [63:0] src_val,
    input logic [63:0] result,
    input logic        illegal
);
    // Port-relation checks on the settled combinational outputs.
    always_comb begin
        p_passthru_r9: assert (!illegal || result == dst_val)
            else $error("illegal encoding altered destination");
        p_bad_code_r9: assert (!(op_code inside {4'h2, 4'h3, 4'h9, 4'he, 4'hf}) || illegal)
            else $error("unsupported code accepted");
        p_nonmov_off_r9: assert (!(op_code != 4'hb && offset_in != 16'h0) || illegal)
            else $error("nonzero offset accepted");
        p_upper_zero_r2: assert (!(!wide_mode && !illegal && op_code != 4'hd) || result[63:32] == 32'h0)
            else $error("32-bit result has upper bits set");
        p_neg_reg_r6: assert (!(op_code == 4'h8 && use_reg) || illegal)
            else $error("register-source negate accepted");
        p_mov_imm_r3: assert (!(op_code == 4'hb && !use_reg && wide_mode && offset_in == 16'h0) ||
                              result == {{32{imm_in[31]}}, imm_in})
            else $error("immediate move not sign-extended");
        p_bsw_zext_r7: assert (!(op_code == 4'hd && !illegal && imm_in == 32'd16) || result[63:16] == 48'h0)
            else $error("16-bit conversion not zero-extended");
        p_movsx_imm_r5: assert (!(op_code == 4'hb && offset_in != 16'h0 && !use_reg) || illegal)
            else $error("sign-extending move with immediate accepted");
    end
endmodule

bind vm_int_alu vm_int_alu_chk u_vm_int_alu_chk (
    .op_code   (op_code),
    .use_reg   (use_reg),
    .wide_mode (wide_mode),
    .offset_in (offset_in),
    .imm_in    (imm_in),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/test_vm_int_alu.sv
module test_vm_int_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic        use_reg = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] offset_in = '0;
    logic [31:0] imm_in = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [63:0] res_le, res_be;
    logic        ill_le, ill_be;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;   // 50 MHz

    vm_int_alu #(.HOST_BIG_ENDIAN(1'b0)) i_vm_int_alu (
        .op_code(op_code), .use_reg(use_reg), .wide_mode(wide_mode), .offset_in(offset_in),
        .imm_in(imm_in), .dst_val(dst_val), .src_val(src_val), .result(res_le), .illegal(ill_le));

    vm_int_alu #(.HOST_BIG_ENDIAN(1'b1)) i_vm_int_alu_be (
        .op_code(op_code), .use_reg(use_reg), .wide_mode(wide_mode), .offset_in(offset_in),
        .imm_in(imm_in), .dst_val(dst_val), .src_val(src_val), .result(res_be), .illegal(ill_be));

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual cycles %0d expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Reference legality, from the requirements.
    function automatic bit ref_illegal(input logic [3:0] op, input bit r, input bit w,
                                       input logic [15:0] off, input logic [31:0] imm);
        if (op inside {4'h0, 4'h1, 4'h4, 4'h5, 4'ha, 4'h6, 4'h7, 4'hc}) return off != 0;
        if (op == 4'h8) return (off != 0) || r;
        if (op == 4'hb) begin
            if (off == 0) return 1'b0;
            if (!r) return 1'b1;
            if (off == 8 || off == 16) return 1'b0;
            return !(w && off == 32);
        end
        if (op == 4'hd) return (off != 0) || !(imm == 16 || imm == 32 || imm == 64) || (w && r);
        return 1'b1;
    endfunction

    // Reference result, computed arithmetically per width.
    function automatic logic [63:0] ref_result(input logic [3:0] op, input bit r, input bit w,
                                               input logic [15:0] off, input logic [31:0] imm,
                                               input logic [63:0] d, input logic [63:0] s, input bit hbe);
        logic [63:0] so;
        logic [31:0] d32, s32;
        logic [63:0] sw;
        if (ref_illegal(op, r, w, off, imm)) return d;
        so  = r ? s : 64'($signed(imm));
        d32 = d[31:0];
        s32 = so[31:0];
        if (op == 4'hd) begin
            if (w || (r != hbe)) begin
                if (imm == 16)      sw = {48'h0, d[7:0], d[15:8]};
                else if (imm == 32) sw = {32'h0, {<<8{d32}}};
                else                sw = {<<8{d}};
            end else begin
                if (imm == 16)      sw = {48'h0, d[15:0]};
                else if (imm == 32) sw = {32'h0, d32};
                else                sw = d;
            end
            return sw;
        end
        if (w) begin
            case (op)
                4'h0: return d + so;
                4'h1: return d - so;
                4'h4: return d | so;
                4'h5: return d & so;
                4'ha: return d ^ so;
                4'h6: return d << so[5:0];
                4'h7: return d >> so[5:0];
                4'hc: return 64'($signed(d) >>> so[5:0]);
                4'h8: return ~d + 64'd1;
                default: begin
                    if (off == 8)  return 64'($signed(s[7:0]));
                    if (off == 16) return 64'($signed(s[15:0]));
                    if (off == 32) return 64'($signed(s[31:0]));
                    return so;
                end
            endcase
        end else begin
            case (op)
                4'h0: return {32'h0, d32 + s32};
                4'h1: return {32'h0, d32 - s32};
                4'h4: return {32'h0, d32 | s32};
                4'h5: return {32'h0, d32 & s32};
                4'ha: return {32'h0, d32 ^ s32};
                4'h6: return {32'h0, d32 << s32[4:0]};
                4'h7: return {32'h0, d32 >> s32[4:0]};
                4'hc: return {32'h0, 32'($signed(d32) >>> s32[4:0])};
                4'h8: return {32'h0, ~d32 + 32'd1};
                default: begin
                    if (off == 8)  return {32'h0, 32'($signed(s[7:0]))};
                    if (off == 16) return {32'h0, 32'($signed(s[15:0]))};
                    return {32'h0, s32};
                end
            endcase
        end
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic [15:0] off, input bit ill);
        if (ill) return "R9";
        case (op)
            4'h6, 4'h7, 4'hc: return "R4";
            4'h8: return "R6";
            4'hb: return (off != 0) ? "R5" : "R3";
            4'hd: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input bit r, input bit w, input logic [15:0] off,
                         input logic [31:0] imm, input logic [63:0] d, input logic [63:0] s);
        @(posedge clk);
        #2;
        op_code = op; use_reg = r; wide_mode = w; offset_in = off;
        imm_in = imm; dst_val = d; src_val = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sweep step: compare both host variants against the reference model.
    task automatic sweep_one(input logic [3:0] op, input bit r, input bit w, input logic [15:0] off,
                             input logic [31:0] imm, input logic [63:0] d, input logic [63:0] s);
        bit ei;
        string rq;
        apply(op, r, w, off, imm, d, s);
        ei = ref_illegal(op, r, w, off, imm);
        rq = req_of(op, off, ei);
        check({rq, " flag le"}, {63'h0, ill_le}, {63'h0, ei});
        check({rq, " flag be"}, {63'h0, ill_be}, {63'h0, ei});
        check({rq, " result le"}, res_le, ref_result(op, r, w, off, imm, d, s, 1'b0));
        check({rq, " result be"}, res_be, ref_result(op, r, w, off, imm, d, s, 1'b1));
    endtask

    logic [63:0] dvals [6];
    logic [63:0] svals [6];
    logic [15:0] offs  [5];
    logic [31:0] imms  [6];

    initial begin
        dvals = '{64'h0, 64'hffff_ffff_ffff_ffff, 64'h1122_3344_5566_7788,
                  64'h8000_0000_8000_0080, 64'h0000_0000_7fff_ffff, 64'hfedc_ba98_7654_3210};
        svals = '{64'h1, 64'h0000_0000_0000_0041, 64'hffff_ffff_ffff_ff80,
                  64'h0123_4567_89ab_8000, 64'h0000_0000_8000_0021, 64'h3f};
        offs  = '{16'd0, 16'd8, 16'd16, 16'd32, 16'd1};
        imms  = '{32'd16, 32'd32, 32'd64, 32'hffff_ffff, 32'd5, 32'h8000_0023};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give a legal zero add.
        apply(4'h0, 0, 0, 0, 0, 0, 0);
        check("R1 idle", res_le, 64'h0);
        check("R9 idle flag", {63'h0, ill_le}, 64'h0);

        // Directed corner cases with hand-worked values.
        apply(4'h0, 1, 1, 0, 0, 64'hffff_ffff_ffff_ffff, 64'h1);
        check("R1 wrap64", res_le, 64'h0);
        apply(4'h0, 1, 0, 0, 0, 64'h1234_5678_ffff_ffff, 64'h1);
        check("R2 wrap32", res_le, 64'h0);
        apply(4'hb, 0, 1, 0, 32'hffff_fffe, 0, 0);
        check("R3 mov imm wide", res_le, 64'hffff_ffff_ffff_fffe);
        apply(4'hb, 0, 0, 0, 32'hffff_fffe, 0, 0);
        check("R3 mov imm narrow", res_le, 64'h0000_0000_ffff_fffe);
        apply(4'h6, 0, 1, 0, 32'd65, 64'h1, 0);
        check("R4 lsh mask64", res_le, 64'h2);
        apply(4'hc, 0, 0, 0, 32'd36, 64'h0000_0000_8000_0000, 0);
        check("R4 arsh32 fill", res_le, 64'h0000_0000_f800_0000);
        apply(4'hb, 1, 1, 16'd16, 0, 0, 64'h0000_0000_0000_8000);
        check("R5 movsx16 wide", res_le, 64'hffff_ffff_ffff_8000);
        apply(4'hb, 1, 0, 16'd32, 0, 64'hdead, 64'h8000_0000);
        check("R5 movsx32 narrow illegal", res_le, 64'hdead);
        apply(4'h8, 0, 1, 0, 0, 64'd5, 0);
        check("R6 neg", res_le, 64'hffff_ffff_ffff_fffb);
        apply(4'hd, 0, 1, 0, 32'd16, 64'h1122_3344_5566_7788, 0);
        check("R7 swap16 zext", res_le, 64'h0000_0000_0000_8877);
        apply(4'hd, 0, 0, 0, 32'd32, 64'h1122_3344_5566_7788, 0);
        check("R8 to-little on little host", res_le, 64'h0000_0000_5566_7788);
        check("R8 to-little on big host", res_be, 64'h0000_0000_8877_6655);
        apply(4'hd, 1, 0, 0, 32'd64, 64'h1122_3344_5566_7788, 0);
        check("R8 to-big on little host", res_le, 64'h8877_6655_4433_2211);
        check("R8 to-big on big host", res_be, 64'h1122_3344_5566_7788);
        apply(4'h2, 1, 1, 0, 0, 64'h55, 64'h3);
        check("R9 mul flag", {63'h0, ill_le}, 64'h1);
        check("R9 mul passthru", res_le, 64'h55);
        apply(4'h0, 1, 1, 16'd4, 0, 64'h77, 64'h1);
        check("R9 offset on add", res_le, 64'h77);

        // Near-exhaustive sweep over codes, modes, source select and fields.
        for (int op = 0; op < 16; op++)
            for (int w = 0; w < 2; w++)
                for (int r = 0; r < 2; r++)
                    for (int o = 0; o < 5; o++)
                        for (int v = 0; v < 6; v++)
                            sweep_one(4'(op), r[0], w[0], offs[o], imms[(v + o) % 6], dvals[v], svals[(v + op) % 6]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule